// File: doc/BRIEF.md
# eMMC PHY Masked-Write Control Register Bank

This block holds the configuration of an eMMC physical layer: tap delays, DLL frequency band, clock and strobe selection, per-line receiver enables, pull-ups, open-drain controls, and the DLL and power word. It also returns a read-only status word that the PHY drives (calibration finished, DLL locked, resistor trim result, external resistor missing). Software reaches it over a plain 32-bit register bus that completes one read or one write per request cycle. Each stored control bit drives a plain output port.

Every write carries its own bit-enable mask in the upper 16 bits of the write data. Only those low-half bits whose enable is set take the new value, so one field can be changed with a single write and no read-modify-write. Offsets that hold no register return zero and raise a one-cycle error flag.

Top module: `emmc_phy_regbank`

## Requirements
- R1: After a synchronous active-low reset, every control output is 0, so the PHY is powered down with its DLL off. `rdata_o` and `err_o` are also 0.
- R2: A write to a control word sets stored bit n (n in 0..15) to `wdata_i[n]` only when `wdata_i[n+16]` is 1. Every other bit of that word keeps its value. A write whose upper half is all zero changes nothing.
- R3: A write changes only the addressed word. A read changes no word.
- R4: A read of a control word returns its stored bits in `rdata_o[15:0]`. Bits that hold no field read 0, and `rdata_o[31:16]` reads 0. The value appears on the clock edge that samples the request and holds until the next read. The implemented bits per word are:
  - word 0: bits 13:0
  - word 1: bits 8:0
  - words 2 to 5: bits 9:0
  - word 6: bits 12:0
- R5: Control word k (k = 0..6) sits at byte offset 4*k. Offset 0x18 is the DLL/power word (word 6). The status word sits at 0x20.
- R6: A read of 0x20 returns these status inputs as sampled on the request cycle, with all higher bits 0:
  - bit 6: calibration done
  - bit 5: DLL ready
  - bits 4:1: trim result
  - bit 0: external resistor absent
- R7: A write to 0x20 changes no control word and raises no error.
- R8: An access to an unmapped offset returns 0 on a read and changes no word. This covers 0x1C, any offset above 0x20, and any offset that is not a multiple of 4. `err_o` is 1 for exactly the one cycle after such a request and 0 after every mapped access.
- R9: Word 0 drives these outputs:
  - `freq_sel_o` from bits 13:12 (0=200, 1=50, 2=100, 3=150 MHz)
  - `otap_en_o` from bit 11
  - `otap_sel_o` from bits 10:7
  - `itap_win_o` from bit 6
  - `itap_sel_o` from bits 5:1
  - `itap_en_o` from bit 0
- R10: Word 1 drives these outputs:
  - `clkbuf_sel_o` from bits 8:6
  - `tx_dly_sel_o` from bit 5
  - `rx_dly_sel_o` from bit 4
  - `strobe_sel_o` from bits 3:0
- R11: Words 2, 3, 4 and 5 drive `rx_en_o`, `pull_up_o`, `od_release_o` and `od_enable_o` from their bits 9:0. Bits 7:0 are the data lines. Bit 9 is strobe and bit 8 is command in words 2, 3 and 5; word 4 swaps them (bit 9 command, bit 8 strobe).
- R12: Word 6 drives these outputs:
  - `cp_trim_o` from bits 12:9
  - `trim_en_o` from bit 8
  - `retrim_o` from bit 7
  - `drv_type_o` from bits 6:4
  - `ret_ctl_o` from bits 3:2
  - `dll_en_o` from bit 1
  - `phy_pwr_up_o` from bit 0 (1 = powered)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | [31:16] bit enables, [15:0] new bits |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Unmapped-offset flag |
| stat_cal_done_i | input | 1 | Calibration done |
| stat_dll_ready_i | input | 1 | DLL locked |
| stat_rtrim_i | input | 4 | Resistor trim result |
| stat_no_ext_res_i | input | 1 | External resistor absent |
| freq_sel_o | output | 2 | DLL frequency band |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap select |
| itap_win_o | output | 1 | Input tap change window |
| itap_sel_o | output | 5 | Input tap select |
| itap_en_o | output | 1 | Input tap delay enable |
| clkbuf_sel_o | output | 3 | Clock buffer select |
| tx_dly_sel_o | output | 1 | Delayed transmit clock select |
| rx_dly_sel_o | output | 1 | Delayed receive clock select |
| strobe_sel_o | output | 4 | Strobe delay select |
| rx_en_o | output | 10 | Receiver enables |
| pull_up_o | output | 10 | Pull-up enables |
| od_release_o | output | 10 | Open-drain release |
| od_enable_o | output | 10 | Open-drain enables |
| cp_trim_o | output | 4 | DLL charge-pump trim |
| trim_en_o | output | 1 | Resistor trim enable |
| retrim_o | output | 1 | Retrim request |
| drv_type_o | output | 3 | Driver type |
| ret_ctl_o | output | 2 | Retention controls |
| dll_en_o | output | 1 | DLL enable |
| phy_pwr_up_o | output | 1 | PHY power-up |

## Verification
The assertions check these rules on every cycle:
- a disabled bit never moves under a write;
- a word without a write never moves at all;
- the address decode never selects two targets;
- every error pulse traces back to an unmapped request;
- a status read echoes the status pins of its request cycle.

Only the bench scenarios can show the rest:
- the mapping from each offset to its field ports;
- the swapped strobe and command bits in one pad word;
- reads at every one of the 256 offsets;
- the all-zero outputs after a reset in the middle of a run.

// File: rtl/phyreg_pkg.sv
// Package phyreg_pkg
// Shared sizes of the PHY control register bank and the mask of implemented
// bits in each control word. Assumes word k lives at byte offset 4*k.
package phyreg_pkg;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int NUM_CTRL   = 7;
    localparam int STATUS_IDX = 8;
    localparam int STATUS_W   = 7;

    // Implemented bits of control word k; all other bits are held at zero.
    function automatic logic [HALF_W-1:0] impl_mask(input int k);
        case (k)
            0:       return 16'h3FFF;
            1:       return 16'h01FF;
            6:       return 16'h1FFF;
            default: return 16'h03FF;
        endcase
    endfunction
endpackage

// File: rtl/phyreg_decode.sv
// Module phyreg_decode
// Turns a byte offset into a one-hot control-word select, a status hit or a
// miss. Assumes aligned 32-bit registers; any offset with addr[1:0] != 0 is a
// miss. Purely combinational.
module phyreg_decode
    import phyreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] sel,
    output logic                stat_hit,
    output logic                miss
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Decode the word index into exactly one target or a miss.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            sel[k] = aligned && (int'(idx) == k);
        end
        stat_hit = aligned && (int'(idx) == STATUS_IDX);
        miss     = !((|sel) || stat_hit);
    end

    AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sel, stat_hit, miss}));  // R5
endmodule

// File: rtl/phyreg_word.sv
// Module phyreg_word
// One masked-write control word. On a write, bit n takes wdata[n] only where
// wmask[n] is set; bits outside IMPL always stay zero. Synchronous reset to 0.
module phyreg_word
    import phyreg_pkg::*;
#(
    parameter logic [HALF_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] wmask,
    output logic [HALF_W-1:0] q
);
    // Merge enabled bits of the write into the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= ((q & ~wmask) | (wdata & wmask)) & IMPL;
        end
    end

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));  // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));  // R3
endmodule

// File: rtl/phyreg_rdmux.sv
// Module phyreg_rdmux
// Registers the read response and the error flag. Read data holds until the
// next read; the error flag is a one-cycle pulse per unmapped request.
module phyreg_rdmux
    import phyreg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req,
    input  logic                           we,
    input  logic [NUM_CTRL-1:0]            sel,
    input  logic                           stat_hit,
    input  logic                           miss,
    input  logic [NUM_CTRL-1:0][HALF_W-1:0] words,
    input  logic [STATUS_W-1:0]            status,
    output logic [DATA_W-1:0]              rdata,
    output logic                           err
);
    logic [DATA_W-1:0] rd_next;

    // Select the read value of the addressed target; misses give zero.
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (sel[k]) rd_next = rd_next | {{HALF_W{1'b0}}, words[k]};
        end
        if (stat_hit) rd_next = {{(DATA_W-STATUS_W){1'b0}}, status};
    end

    // Capture the response on the request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= req && miss;
            if (req && !we) rdata <= rd_next;
        end
    end

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req && miss));  // R8
    AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && stat_hit) |=> (rdata[STATUS_W-1:0] == $past(status)));  // R6
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && miss) |=> (rdata == '0));  // R8
endmodule

// File: rtl/emmc_phy_regbank.sv
// Module emmc_phy_regbank
// Top of the eMMC PHY control register bank: address decode, seven masked
// control words, registered readback with status, and field output ports.
// Assumes one access per request cycle and status inputs stable on reads.
module emmc_phy_regbank
    import phyreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              err_o,
    input  logic              stat_cal_done_i,
    input  logic              stat_dll_ready_i,
    input  logic [3:0]        stat_rtrim_i,
    input  logic              stat_no_ext_res_i,
    output logic [1:0]        freq_sel_o,
    output logic              otap_en_o,
    output logic [3:0]        otap_sel_o,
    output logic              itap_win_o,
    output logic [4:0]        itap_sel_o,
    output logic              itap_en_o,
    output logic [2:0]        clkbuf_sel_o,
    output logic              tx_dly_sel_o,
    output logic              rx_dly_sel_o,
    output logic [3:0]        strobe_sel_o,
    output logic [9:0]        rx_en_o,
    output logic [9:0]        pull_up_o,
    output logic [9:0]        od_release_o,
    output logic [9:0]        od_enable_o,
    output logic [3:0]        cp_trim_o,
    output logic              trim_en_o,
    output logic              retrim_o,
    output logic [2:0]        drv_type_o,
    output logic [1:0]        ret_ctl_o,
    output logic              dll_en_o,
    output logic              phy_pwr_up_o
);
    logic [NUM_CTRL-1:0]             sel;
    logic                            stat_hit;
    logic                            miss;
    logic [NUM_CTRL-1:0]             wr_en;
    logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
    logic [STATUS_W-1:0]             status;

    phyreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_i),
        .sel      (sel),
        .stat_hit (stat_hit),
        .miss     (miss)
    );

    // Gate the one-hot select with a write request.
    always_comb begin
        wr_en = (req_i && we_i) ? sel : '0;
    end

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
        phyreg_word #(.IMPL(impl_mask(k))) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en[k]),
            .wdata (wdata_i[HALF_W-1:0]),
            .wmask (wdata_i[DATA_W-1:HALF_W]),
            .q     (ctrl_q[k])
        );
    end

    // Assemble the status word from the PHY status pins.
    always_comb begin
        status = {stat_cal_done_i, stat_dll_ready_i, stat_rtrim_i, stat_no_ext_res_i};
    end

    phyreg_rdmux u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_i),
        .we       (we_i),
        .sel      (sel),
        .stat_hit (stat_hit),
        .miss     (miss),
        .words    (ctrl_q),
        .status   (status),
        .rdata    (rdata_o),
        .err      (err_o)
    );

    // Word 0: tap delays and DLL frequency band.
    assign freq_sel_o   = ctrl_q[0][13:12];
    assign otap_en_o    = ctrl_q[0][11];
    assign otap_sel_o   = ctrl_q[0][10:7];
    assign itap_win_o   = ctrl_q[0][6];
    assign itap_sel_o   = ctrl_q[0][5:1];
    assign itap_en_o    = ctrl_q[0][0];
    // Word 1: clock buffer and strobe selection.
    assign clkbuf_sel_o = ctrl_q[1][8:6];
    assign tx_dly_sel_o = ctrl_q[1][5];
    assign rx_dly_sel_o = ctrl_q[1][4];
    assign strobe_sel_o = ctrl_q[1][3:0];
    // Words 2..5: per-line pad controls.
    assign rx_en_o      = ctrl_q[2][9:0];
    assign pull_up_o    = ctrl_q[3][9:0];
    assign od_release_o = ctrl_q[4][9:0];
    assign od_enable_o  = ctrl_q[5][9:0];
    // Word 6: DLL and power control.
    assign cp_trim_o    = ctrl_q[6][12:9];
    assign trim_en_o    = ctrl_q[6][8];
    assign retrim_o     = ctrl_q[6][7];
    assign drv_type_o   = ctrl_q[6][6:4];
    assign ret_ctl_o    = ctrl_q[6][3:2];
    assign dll_en_o     = ctrl_q[6][1];
    assign phy_pwr_up_o = ctrl_q[6][0];

    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && stat_hit) |=> $stable(ctrl_q));  // R7
endmodule

// File: tb/tb_emmc_phy_regbank.sv
// Bench tb_emmc_phy_regbank
// Sweeps every offset, masked writes on every word, status combinations and
// resets, against a bench-side model of the stored words.
module tb_emmc_phy_regbank;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              err_o;
    logic              st_cal = 1'b0, st_dll = 1'b0, st_noext = 1'b0;
    logic [3:0]        st_trim = '0;
    logic [1:0]  freq_sel_o;  logic otap_en_o;  logic [3:0] otap_sel_o;
    logic itap_win_o;  logic [4:0] itap_sel_o;  logic itap_en_o;
    logic [2:0] clkbuf_sel_o;  logic tx_dly_sel_o, rx_dly_sel_o;  logic [3:0] strobe_sel_o;
    logic [9:0] rx_en_o, pull_up_o, od_release_o, od_enable_o;
    logic [3:0] cp_trim_o;  logic trim_en_o, retrim_o;  logic [2:0] drv_type_o;
    logic [1:0] ret_ctl_o;  logic dll_en_o, phy_pwr_up_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] model [7];

    always #10 clk = ~clk;

    emmc_phy_regbank #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
        .stat_cal_done_i(st_cal), .stat_dll_ready_i(st_dll),
        .stat_rtrim_i(st_trim), .stat_no_ext_res_i(st_noext),
        .freq_sel_o(freq_sel_o), .otap_en_o(otap_en_o), .otap_sel_o(otap_sel_o),
        .itap_win_o(itap_win_o), .itap_sel_o(itap_sel_o), .itap_en_o(itap_en_o),
        .clkbuf_sel_o(clkbuf_sel_o), .tx_dly_sel_o(tx_dly_sel_o),
        .rx_dly_sel_o(rx_dly_sel_o), .strobe_sel_o(strobe_sel_o),
        .rx_en_o(rx_en_o), .pull_up_o(pull_up_o), .od_release_o(od_release_o),
        .od_enable_o(od_enable_o), .cp_trim_o(cp_trim_o), .trim_en_o(trim_en_o),
        .retrim_o(retrim_o), .drv_type_o(drv_type_o), .ret_ctl_o(ret_ctl_o),
        .dll_en_o(dll_en_o), .phy_pwr_up_o(phy_pwr_up_o)
    );

    function automatic logic [15:0] impl(input int k);
        int w;
        case (k)
            0: w = 14;
            1: w = 9;
            6: w = 13;
            default: w = 10;
        endcase
        return 16'((32'd1 << w) - 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request cycle; response sampled away from the edge.
    task automatic access(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        rd = rdata_o; er = err_o;
    endtask

    task automatic check_ports(input string tag);
        check({"R9 ", tag}, 32'({freq_sel_o, otap_en_o, otap_sel_o, itap_win_o, itap_sel_o, itap_en_o}),
              32'(model[0] & 16'h3FFF));
        check({"R10 ", tag}, 32'({clkbuf_sel_o, tx_dly_sel_o, rx_dly_sel_o, strobe_sel_o}),
              32'(model[1] & 16'h01FF));
        check({"R11 rx ", tag}, 32'(rx_en_o), 32'(model[2][9:0]));
        check({"R11 pu ", tag}, 32'(pull_up_o), 32'(model[3][9:0]));
        check({"R11 odr ", tag}, 32'(od_release_o), 32'(model[4][9:0]));
        check({"R11 ode ", tag}, 32'(od_enable_o), 32'(model[5][9:0]));
        check({"R12 ", tag}, 32'({cp_trim_o, trim_en_o, retrim_o, drv_type_o, ret_ctl_o, dll_en_o, phy_pwr_up_o}),
              32'(model[6] & 16'h1FFF));
    endtask

    function automatic logic [31:0] expect_read(input int a, output logic er);
        int idx = a / 4;
        er = 1'b0;
        if (a % 4 != 0) begin er = 1'b1; return 0; end
        if (idx < 7) return 32'(model[idx]);
        if (idx == 8) return 32'({st_cal, st_dll, st_trim, st_noext});
        er = 1'b1;
        return 0;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, exp;
        logic er, eer;
        for (int k = 0; k < 7; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_ports("R1 reset");
        check("R1 rdata", rdata_o, 0);
        check("R1 err", 32'(err_o), 0);

        // Preload pad and control words through a full-mask write.
        for (int k = 0; k < 7; k++) begin
            logic [15:0] v = 16'(16'hA5C3 ^ (k * 16'h1111));
            access(1'b1, 8'(k * 4), {16'hFFFF, v}, rd, er);
            model[k] = v & impl(k);
            check("R8 mapped write err", 32'(er), 0);
        end
        check_ports("R2 preload");

        // R4 R5 R6 R8: read sweep over all 256 offsets.
        st_cal = 1'b1; st_dll = 1'b0; st_trim = 4'hA; st_noext = 1'b1;
        for (int a = 0; a < 256; a++) begin
            access(1'b0, 8'(a), 32'h0, rd, er);
            exp = expect_read(a, eer);
            check("R4 R5 R6 R8 read value", rd, exp);
            check("R8 err flag", 32'(er), 32'(eer));
        end
        @(negedge clk);
        check("R8 err one cycle", 32'(err_o), 0);

        // R2 R3: masked writes with varied patterns on each word.
        for (int k = 0; k < 7; k++) begin
            for (int i = 0; i < 24; i++) begin
                logic [15:0] m = 16'((i * 16'h2F1B + k * 16'h0939) ^ (16'h1 << i[3:0]));
                logic [15:0] d = 16'(i * 16'h9E37 + k * 16'h5A5);
                access(1'b1, 8'(k * 4), {m, d}, rd, er);
                model[k] = ((model[k] & ~m) | (d & m)) & impl(k);
                check_ports("R2 R3 masked write");
                access(1'b0, 8'(k * 4), 32'h0, rd, er);
                check("R2 R4 readback", rd, 32'(model[k]));
            end
            // R2: empty mask changes nothing.
            access(1'b1, 8'(k * 4), 32'h0000_FFFF, rd, er);
            check_ports("R2 empty mask");
        end

        // R7: full-mask write to status is inert and raises no error.
        access(1'b1, 8'h20, 32'hFFFF_FFFF, rd, er);
        check("R7 err", 32'(er), 0);
        check_ports("R7 status write");

        // R8: full-mask writes to unmapped offsets change nothing.
        for (int a = 0; a < 256; a++) begin
            exp = expect_read(a, eer);
            if (eer) begin
                access(1'b1, 8'(a), 32'hFFFF_FFFF, rd, er);
                check("R8 write err", 32'(er), 1);
            end
        end
        check_ports("R8 unmapped writes");

        // R6: every status combination.
        for (int s = 0; s < 128; s++) begin
            {st_cal, st_dll, st_trim, st_noext} = 7'(s);
            access(1'b0, 8'h20, 32'h0, rd, er);
            check("R6 status", rd, 32'(s));
        end

        // R1: reset mid-run returns everything to zero.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 7; k++) model[k] = '0;
        check_ports("R1 rereset");
        check("R1 rdata after reset", rdata_o, 0);
        access(1'b0, 8'h18, 32'h0, rd, er);
        check("R1 dll word zero", rd, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule